// File: doc/BRIEF.md
# Multiplexed-Bus Byte Read Sequencer

This block performs asynchronous read cycles on an external bus where the address and the data share pins. A host hands it one request made of a 16-bit address, a read length counted in core-clock cycles and a flag that adds one trailing cycle. The block then runs the whole access on the pins.

First it drives the full address with both output-enable groups on and pulses the address-latch strobe so that an external latch can hold the address. It keeps the low byte on the bus for one more cycle and then releases it for a turnaround cycle. Next it holds the read strobe low for the programmed length and takes the returned byte from the low lane on the clock edge where the strobe returns high. The upper address byte stays driven up to that edge, and for one extra cycle when the hold flag is set. The write strobe is never asserted.

The byte goes back to the host on a valid/ready response channel. The response stays valid, with its data frozen, until the host signals ready. The block accepts no new request until the response has been taken. On the request channel, `req_ready` is high only while the block is idle. A request that is presented while the block is busy is neither acknowledged nor started. The host must keep it valid until it sees ready.

Top module: `mux_rd_seq`

## Requirements
- R1: After reset the block is idle, with `req_ready`=1, `rsp_valid`=0, `rd_n`=1, `wr_n`=1 and both output enables at 0. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. While a cycle is in progress `req_ready` is 0, and a request presented then starts no bus activity.
- R2: After a request is accepted, the latch strobe is active for exactly 2 cycles. During those cycles `ad_out` equals the requested address and both `ad_oe_lo` and `ad_oe_hi` are 1.
- R3: The strobe polarity is set by `cfg_ale_low`. At 0 the strobe is active high and idles low. At 1 it is active low and idles high.
- R4: Between the end of the latch strobe and the fall of `rd_n` there are exactly 2 cycles. In the first of them `ad_oe_lo` is still 1. In the second `ad_oe_lo` is 0.
- R5: `rd_n` is 0 for exactly D consecutive cycles, where D is `req_cycles` (4 bits). A value of 0 gives D=1.
- R6: `rsp_data` is the value of `ad_in` at the clock edge on which `rd_n` returns to 1.
- R7: `ad_oe_hi` stays 1, with `ad_out[15:8]` equal to the upper address byte, from the latch strobe until `rd_n` rises. It then stays 1 for exactly one more cycle if `req_hold` was 1, and for zero cycles if it was 0.
- R8: `wr_n` is 1 at all times.
- R9: `rsp_valid` rises in the cycle after the read or hold phase ends. While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid` stays 1 and `rsp_data` stays unchanged. The block returns to idle on the edge where both are 1.
- R10: `ad_oe_lo` is never 1 while `rd_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ale_low | input | 1 | 1 selects an active-low latch strobe |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_addr | input | 16 | Read address |
| req_cycles | input | 4 | Read strobe length in cycles (0 acts as 1) |
| req_hold | input | 1 | Adds one trailing upper-address cycle |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_data | output | 8 | Captured byte |
| ad_out | output | 16 | Address/data bus output value |
| ad_oe_lo | output | 1 | Output enable for bus bits 7..0 |
| ad_oe_hi | output | 1 | Output enable for bus bits 15..8 |
| ad_in | input | 8 | Bus bits 7..0 as read back from the pins |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The two hardest situations to reach from the ports are a second request that arrives while a cycle is already on the bus, and a response that the host refuses to take. To reach the first, the bench presents a different address during the address-hold and turnaround cycles. It then checks that ready stayed low, that the response and the address seen on the bus belong to the first request, and that no latch strobe follows. To reach the second, the bench holds `rsp_ready` low for several cycles after the response appears and checks that the byte stays fixed. The bench models the memory by driving `ad_in` with the byte only while `rd_n` is low. Because of this, capturing the byte on any other edge returns a visibly wrong value.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ALE,
    PH_AHOLD,
    PH_TURN,
    PH_READ,
    PH_HOLD,
    PH_RESP
  } phase_t;
endpackage

// File: rtl/mrs_timer.sv
module mrs_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/mrs_fsm.sv
module mrs_fsm
  import mrs_pkg::*;
#(
  parameter int AW        = 16,
  parameter int CNT_W     = 4,
  parameter int ALE_CYC   = 2,
  parameter int AHOLD_CYC = 1,
  parameter int TURN_CYC  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic [CNT_W-1:0] req_cycles,
  input  logic             req_hold,
  input  logic             rsp_ready,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output phase_t           phase,
  output logic [AW-1:0]    addr_q,
  output logic             req_ready,
  output logic             capture
);
  localparam logic [CNT_W-1:0] ALE_LD   = CNT_W'(ALE_CYC - 1);
  localparam logic [CNT_W-1:0] AHOLD_LD = CNT_W'(AHOLD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_CYC - 1);

  phase_t           nxt;
  logic [CNT_W-1:0] cyc_q;
  logic             hold_q;
  logic [CNT_W-1:0] read_ld;
  logic             accept;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_ready && req_valid;
  assign read_ld   = (cyc_q == '0) ? '0 : cyc_q - 1'b1;
  assign capture   = (phase == PH_READ) && tmr_expired;

  always_comb begin
    nxt      = phase;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase)
      PH_IDLE:  if (req_valid) begin nxt = PH_ALE; tmr_load = 1'b1; tmr_val = ALE_LD; end
      PH_ALE:   if (tmr_expired) begin nxt = PH_AHOLD; tmr_load = 1'b1; tmr_val = AHOLD_LD; end
      PH_AHOLD: if (tmr_expired) begin nxt = PH_TURN; tmr_load = 1'b1; tmr_val = TURN_LD; end
      PH_TURN:  if (tmr_expired) begin nxt = PH_READ; tmr_load = 1'b1; tmr_val = read_ld; end
      PH_READ:  if (tmr_expired) begin
                  nxt = hold_q ? PH_HOLD : PH_RESP;
                  tmr_load = 1'b1;
                end
      PH_HOLD:  if (tmr_expired) nxt = PH_RESP;
      PH_RESP:  if (rsp_ready) nxt = PH_IDLE;
      default:  nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      addr_q <= '0;
      cyc_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      phase <= nxt;
      if (accept) begin
        addr_q <= req_addr;
        cyc_q  <= req_cycles;
        hold_q <= req_hold;
      end
    end
  end

  assert_accept_starts_ale_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (phase == PH_ALE));
  assert_busy_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && phase != PH_RESP) |=> (phase != PH_IDLE));
endmodule

// File: rtl/mrs_pins.sv
module mrs_pins
  import mrs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_t        phase,
  input  logic [AW-1:0] addr_q,
  input  logic          cfg_ale_low,
  input  logic [DW-1:0] ad_in,
  input  logic          capture,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic [AW-1:0] ad_out,
  output logic          ad_oe_lo,
  output logic          ad_oe_hi,
  output logic [DW-1:0] rsp_data
);
  logic ale_act;

  assign ale_act  = (phase == PH_ALE);
  assign ale      = ale_act ^ cfg_ale_low;
  assign rd_n     = (phase != PH_READ);
  assign wr_n     = 1'b1;
  assign ad_oe_lo = (phase == PH_ALE) || (phase == PH_AHOLD);
  assign ad_oe_hi = (phase == PH_ALE) || (phase == PH_AHOLD) || (phase == PH_TURN)
                 || (phase == PH_READ) || (phase == PH_HOLD);
  assign ad_out   = {addr_q[AW-1:DW], ad_oe_lo ? addr_q[DW-1:0] : {DW{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rsp_data <= '0;
    else if (capture) rsp_data <= ad_in;
  end

  assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ad_oe_lo && !rd_n));
  assert_capture_at_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> rd_n);
endmodule

// File: rtl/mux_rd_seq.sv
module mux_rd_seq
  import mrs_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int CNT_W     = 4,
  parameter int ALE_CYC   = 2,
  parameter int AHOLD_CYC = 1,
  parameter int TURN_CYC  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ale_low,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [CNT_W-1:0] req_cycles,
  input  logic             req_hold,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_data,
  output logic [AW-1:0]    ad_out,
  output logic             ad_oe_lo,
  output logic             ad_oe_hi,
  input  logic [DW-1:0]    ad_in,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n
);
  localparam int RUN_W = CNT_W + 2;

  phase_t           phase;
  logic [AW-1:0]    addr_q;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             capture;

  mrs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  mrs_fsm #(.AW(AW), .CNT_W(CNT_W), .ALE_CYC(ALE_CYC), .AHOLD_CYC(AHOLD_CYC),
            .TURN_CYC(TURN_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_cycles(req_cycles), .req_hold(req_hold), .rsp_ready(rsp_ready),
    .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .phase(phase), .addr_q(addr_q), .req_ready(req_ready), .capture(capture)
  );

  mrs_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst_n(rst_n), .phase(phase), .addr_q(addr_q), .cfg_ale_low(cfg_ale_low),
    .ad_in(ad_in), .capture(capture), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe_lo(ad_oe_lo), .ad_oe_hi(ad_oe_hi), .rsp_data(rsp_data)
  );

  assign rsp_valid = (phase == PH_RESP);

  // Width checkers built from the pins: run-length counters of each strobe.
  logic             ale_on, ale_prev;
  logic [RUN_W-1:0] ale_run, rd_run;
  logic [RUN_W-1:0] exp_d;

  assign ale_on = ale ^ cfg_ale_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_prev <= 1'b0;
      ale_run  <= '0;
      rd_run   <= '0;
      exp_d    <= '0;
    end else begin
      ale_prev <= ale_on;
      ale_run  <= ale_on ? ale_run + 1'b1 : '0;
      rd_run   <= !rd_n ? rd_run + 1'b1 : '0;
      if (req_valid && req_ready)
        exp_d <= (req_cycles == '0) ? RUN_W'(1) : RUN_W'(req_cycles);
    end
  end

  assert_ale_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_prev && !ale_on) |-> (ale_run == RUN_W'(ALE_CYC)));
  assert_rd_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && capture) |=> (rd_run == exp_d));
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: tb/tb_mux_rd_seq.sv
module tb_mux_rd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_ale_low = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_cycles = '0;
  logic        req_hold = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic [15:0] ad_out;
  logic        ad_oe_lo, ad_oe_hi;
  logic [7:0]  ad_in;
  logic        ale, rd_n, wr_n;
  logic [7:0]  mem_byte = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  // Memory model: byte appears on the low lane only while the read strobe is low.
  assign ad_in = rd_n ? 8'h00 : mem_byte;

  mux_rd_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_ale_low(cfg_ale_low), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_cycles(req_cycles), .req_hold(req_hold),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .ad_out(ad_out),
    .ad_oe_lo(ad_oe_lo), .ad_oe_hi(ad_oe_hi), .ad_in(ad_in), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {addr[15:0], cycles[3:0], hold, ale_low, data[7:0]}
  localparam logic [29:0] VEC [6] = '{
    {16'h1234, 4'd1,  1'b0, 1'b0, 8'hA5},
    {16'hBEEF, 4'd3,  1'b1, 1'b0, 8'h5A},
    {16'h00FF, 4'd0,  1'b0, 1'b0, 8'h3C},
    {16'hFF00, 4'd15, 1'b1, 1'b1, 8'hC3},
    {16'h8001, 4'd2,  1'b0, 1'b1, 8'h00},
    {16'h7FFE, 4'd7,  1'b1, 1'b0, 8'hFF}
  };

  task automatic do_read(input logic [15:0] a, input logic [3:0] c, input logic h,
                         input logic low, input logic [7:0] d, input int bp, input bit poke);
    int n = 0, ale_cnt = 0, rd_cnt = 0, last_ale = -1, first_rd = -1, hold_cnt = 0;
    bit addr_ok = 1, wr_ok = 1, cont_ok = 1, hi_ok = 1, ahold_ok = 1, rd_done = 0;
    bit prev_oe_lo = 0, busy_ok = 1;
    int exp_d = (c == 0) ? 1 : int'(c);
    @(negedge clk);
    cfg_ale_low = low; mem_byte = d;
    req_addr = a; req_cycles = c; req_hold = h; req_valid = 1'b1;
    rsp_ready = (bp == 0);
    @(posedge clk); #1 req_valid = 1'b0;
    forever begin
      @(negedge clk);
      n++;
      if (poke && n == 3) begin
        if (req_ready !== 1'b0) busy_ok = 0;
        req_addr = 16'hDEAD; req_valid = 1'b1;
      end
      if (poke && n == 5) req_valid = 1'b0;
      if (wr_n !== 1'b1) wr_ok = 0;
      if (ad_oe_lo && !rd_n) cont_ok = 0;
      if (ale !== low) begin
        ale_cnt++; last_ale = n;
        if (ad_out !== a || !ad_oe_lo || !ad_oe_hi) addr_ok = 0;
      end else if (last_ale == n - 1 && first_rd < 0 && !ad_oe_lo) ahold_ok = 0;
      if (!rd_n) begin
        if (first_rd < 0) begin
          first_rd = n;
          check("R4 low lane released before read", prev_oe_lo, 0);
        end
        rd_cnt++;
        if (!ad_oe_hi || ad_out[15:8] !== a[15:8]) hi_ok = 0;
      end else if (first_rd >= 0) rd_done = 1;
      if (rd_done && !rsp_valid && ad_oe_hi) begin
        hold_cnt++;
        if (ad_out[15:8] !== a[15:8]) hi_ok = 0;
      end
      prev_oe_lo = ad_oe_lo;
      if (rsp_valid) break;
      if (n > 60) break;
    end
    check("R2 latch strobe width", ale_cnt, 2);
    check("R2 address on bus during strobe", addr_ok, 1);
    check("R4 gap strobe to read", first_rd - last_ale - 1, 2);
    check("R4 low byte held one cycle", ahold_ok, 1);
    check("R5 read strobe width", rd_cnt, exp_d);
    check("R6 captured byte", rsp_data, d);
    check("R7 upper hold cycles", hold_cnt, h);
    check("R7 upper address driven", hi_ok, 1);
    check("R8 write strobe idle", wr_ok, 1);
    check("R10 no contention", cont_ok, 1);
    check("R9 response valid", rsp_valid, 1);
    if (poke) check("R1 not ready while busy", busy_ok, 1);
    for (int k = 0; k < bp; k++) begin
      @(negedge clk);
      check("R9 valid held under back-pressure", rsp_valid, 1);
      check("R9 data held under back-pressure", rsp_data, d);
    end
    if (bp != 0) rsp_ready = 1'b1;
    @(negedge clk);
    check("R9 response taken", rsp_valid, 0);
    check("R1 idle after response", req_ready, 1);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check("R1 busy request started nothing", {ale, ad_oe_hi}, {low, 1'b0});
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset ready", req_ready, 1);
    check("R1 reset rsp_valid", rsp_valid, 0);
    check("R1 reset strobes", {rd_n, wr_n}, 2'b11);
    check("R1 reset enables", {ad_oe_lo, ad_oe_hi}, 2'b00);
    check("R3 idle level active-high", ale, 0);
    cfg_ale_low = 1'b1;
    @(negedge clk);
    check("R3 idle level active-low", ale, 1);
    cfg_ale_low = 1'b0;

    foreach (VEC[i])
      do_read(VEC[i][29:14], VEC[i][13:10], VEC[i][9], VEC[i][8], VEC[i][7:0], 0, 0);

    // Directed: back-pressure on the response (R9)
    do_read(16'h4321, 4'd2, 1'b1, 1'b0, 8'h96, 4, 0);
    // Directed: request presented while busy is ignored (R1)
    do_read(16'h0F0F, 4'd4, 1'b0, 1'b0, 8'h69, 0, 1);
    // Directed: zero length with active-low strobe and back-pressure (R5, R3)
    do_read(16'hA0A0, 4'd0, 1'b1, 1'b1, 8'h81, 2, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule